// File: doc/BRIEF.md
# Interrupt Redirection Controller

The controller watches a bank of interrupt input pins and turns each request into a delivery message for the processor side of the system. Every pin has a 64-bit redirection entry. The entry holds the vector, the delivery mode, the destination, the destination mode, the polarity and the trigger mode, and it also carries a mask bit. Software never addresses an entry directly. It first writes an index into a select location and then reads or writes the chosen 32-bit half through a data window.

Requests are captured per pin. An edge-mode pin latches a rising transition until its message has been accepted. A level-mode pin simply mirrors its input. A sequencer picks the lowest-numbered pending pin that is not masked and builds a message from that pin's entry. It holds the message on a valid/ready output until the consumer accepts it, and only then looks for the next pin. Decoding the destination into processors, and returning end-of-interrupt, are left to neighbouring blocks.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: After reset, the select register reads 0, the controller ID is 0, every entry's low half reads 0x00010000 (only the mask bit 16 set), every high half reads 0, and msg_valid is low.
- R2: A write at offset 0x00 loads the select index from bits [7:0], and a read at 0x00 returns it. Through the window at offset 0x10, select value 0x00 is the ID register. Only bits [31:24] are stored, and the other bits read back 0.
- R3: Select value 0x01 is read-only. It reads as version 0x11 in bits [7:0] and the highest pin index (23) in bits [23:16], which gives 0x00170011, and a write to it changes nothing.
- R4: Select value 0x10+2n reaches bits [31:0] of entry n, and 0x11+2n reaches bits [63:32]. Writing one half leaves the other half unchanged.
- R5: A select value that names no register (0x02 to 0x0F, or above 0x3F) reads 0 and ignores writes. An offset other than 0x00 or 0x10 reads 0.
- R6: When trigger bit 15 of an entry is 1 (level mode), the pin's pending state follows its input. The pin keeps producing messages while the input is high and stops once the input is low.
- R7: When trigger bit 15 is 0 (edge mode), a rising input sets the pending state. Acceptance of that pin's message clears it, so an input that stays high produces exactly one message, and a new rising edge produces another.
- R8: A pin whose mask bit 16 is 1 produces no message. An edge captured while the pin is masked stays pending and is delivered once the mask is cleared.
- R9: When several pins are pending and unmasked, their messages come out in ascending pin order.
- R10: While msg_valid is high and msg_ready is low, msg_valid stays high and every message field stays stable.
- R11: The message fields carry the pin's entry at capture time: vector from [7:0], delivery mode from [10:8], destination mode from bit 11, polarity from bit 13, trigger from bit 15, destination from [63:56], and msg_pin gives the pin index.
- R12: With the sequencer idle and an unmasked edge-mode pin, msg_valid rises on the second rising clock edge after the input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_we | input | 1 | Register write strobe |
| acc_off | input | 8 | Access offset: 0x00 select, 0x10 data window |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the current offset, combinational |
| irq_in | input | PINS (24) | Interrupt input pins |
| msg_valid | output | 1 | Delivery message is present |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Vector |
| msg_dmode | output | 3 | Delivery mode |
| msg_destmode | output | 1 | Destination mode |
| msg_pol | output | 1 | Polarity |
| msg_trig | output | 1 | Trigger mode, 1 means level |
| msg_dest | output | 8 | Destination |
| msg_pin | output | PIN_W (5) | Index of the source pin |

## Verification
Register writes take effect at the clock edge that samples them. A window read is combinational, so the bench reads it a moment after it sets the offset, before the next edge. An input edge reaches the pending state at the first clock edge and the message register at the second. The bench therefore checks that msg_valid is low one falling edge after it raises a pin, and high one falling edge later. A handshake completes at the edge where valid and ready are both high, and the pending state of an edge-mode pin is cleared at that same edge. So the "no further message" checks start after that edge and run over several idle cycles, with every sample taken at the falling edge.

// File: rtl/irc_pkg.sv
// Shared constants, message type and entry decode for the redirection controller.
// Assumes 8-bit offsets and 8-bit select indices.
package irc_pkg;

    localparam logic [7:0] OFF_SEL    = 8'h00;
    localparam logic [7:0] OFF_WIN    = 8'h10;
    localparam logic [7:0] IDX_ID     = 8'h00;
    localparam logic [7:0] IDX_VER    = 8'h01;
    localparam logic [7:0] IDX_ENTRY0 = 8'h10;
    localparam logic [7:0] VERSION    = 8'h11;

    localparam int MASK_BIT = 16;
    localparam int TRIG_BIT = 15;
    localparam int POL_BIT  = 13;
    localparam int DSTM_BIT = 11;

    localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

    typedef struct packed {
        logic [7:0] dest;
        logic       trig;
        logic       pol;
        logic       dstm;
        logic [2:0] dmode;
        logic [7:0] vector;
    } msg_t;

    // Pull the delivery fields out of a 64-bit entry.
    function automatic msg_t entry_to_msg(input logic [63:0] e);
        msg_t m;
        m.vector = e[7:0];
        m.dmode  = e[10:8];
        m.dstm   = e[DSTM_BIT];
        m.pol    = e[POL_BIT];
        m.trig   = e[TRIG_BIT];
        m.dest   = e[63:56];
        return m;
    endfunction

endpackage

// File: rtl/irc_regfile.sv
// Register file behind the select/window pair: ID, version and the per-pin
// 64-bit redirection entries, each written as two independent 32-bit halves.
// Assumes 0x10 + 2*PINS - 1 fits in the 8-bit select index.
module irc_regfile
    import irc_pkg::*;
#(
    parameter int PINS = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_we,
    input  logic [7:0]  acc_off,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    output logic [7:0]  sel_o,
    output logic [63:0] entry_o [PINS],
    output logic [PINS-1:0] mask_o,
    output logic [PINS-1:0] trig_o
);

    localparam logic [7:0]  MAX_PIN  = 8'(PINS - 1);
    localparam logic [31:0] VER_WORD = {8'h00, MAX_PIN, 8'h00, VERSION};

    logic [7:0]  sel_q;
    logic [7:0]  id_q;
    logic [63:0] ent_q [PINS];
    logic        win_wr;
    logic [31:0] win_val;

    assign win_wr = acc_we && (acc_off == OFF_WIN);
    assign sel_o  = sel_q;

    // Select index register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (acc_we && acc_off == OFF_SEL)
            sel_q <= acc_wdata[7:0];
    end

    // Controller ID, top byte only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_q <= '0;
        else if (win_wr && sel_q == IDX_ID)
            id_q <= acc_wdata[31:24];
    end

    for (genvar g = 0; g < PINS; g++) begin : g_ent
        localparam logic [7:0] LO_IDX = IDX_ENTRY0 + 8'(2 * g);
        localparam logic [7:0] HI_IDX = LO_IDX + 8'd1;

        // One entry, low and high halves written separately.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[g] <= ENTRY_RST;
            else if (win_wr && sel_q == LO_IDX)
                ent_q[g][31:0] <= acc_wdata;
            else if (win_wr && sel_q == HI_IDX)
                ent_q[g][63:32] <= acc_wdata;
        end

        assign entry_o[g] = ent_q[g];
        assign mask_o[g]  = ent_q[g][MASK_BIT];
        assign trig_o[g]  = ent_q[g][TRIG_BIT];
    end

    // Window read mux over the selected register.
    always_comb begin
        win_val = '0;
        if (sel_q == IDX_ID)
            win_val = {id_q, 24'h0};
        else if (sel_q == IDX_VER)
            win_val = VER_WORD;
        for (int i = 0; i < PINS; i++) begin
            if (sel_q == IDX_ENTRY0 + 8'(2 * i))
                win_val = ent_q[i][31:0];
            else if (sel_q == IDX_ENTRY0 + 8'(2 * i + 1))
                win_val = ent_q[i][63:32];
        end
    end

    // Offset decode for reads.
    always_comb begin
        if (acc_off == OFF_SEL)
            acc_rdata = {24'h0, sel_q};
        else if (acc_off == OFF_WIN)
            acc_rdata = win_val;
        else
            acc_rdata = '0;
    end

endmodule

// File: rtl/irc_pending.sv
// Per-pin request capture. Level pins mirror their input; edge pins latch a
// rising transition until the sequencer reports acceptance of that pin.
// Assumes irq_in is already synchronous to clk.
module irc_pending #(
    parameter int PINS  = 24,
    parameter int PIN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PINS-1:0]  irq_in,
    input  logic [PINS-1:0]  trig_level,
    input  logic             clr_valid,
    input  logic [PIN_W-1:0] clr_pin,
    output logic [PINS-1:0]  pend_o
);

    logic [PINS-1:0] prev_q;
    logic [PINS-1:0] pend_q;
    logic [PINS-1:0] rise;

    assign rise   = irq_in & ~prev_q;
    assign pend_o = pend_q;

    // Previous input sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= irq_in;
    end

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        // Pending state of one pin; a new edge wins over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[g] <= 1'b0;
            else if (trig_level[g])
                pend_q[g] <= irq_in[g];
            else if (rise[g])
                pend_q[g] <= 1'b1;
            else if (clr_valid && clr_pin == PIN_W'(g))
                pend_q[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/irc_sequencer.sv
// Picks the lowest eligible pin, captures its entry into a message register and
// holds it under valid/ready. Reports accepted edge-mode pins for clearing.
// Assumes elig already combines pending and mask.
module irc_sequencer
    import irc_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int PIN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PINS-1:0]  elig,
    input  logic [63:0]      entry_i [PINS],
    input  logic             msg_ready,
    output logic             msg_valid,
    output msg_t             msg_o,
    output logic [PIN_W-1:0] pin_o,
    output logic             clr_valid,
    output logic [PIN_W-1:0] clr_pin
);

    logic             valid_q;
    msg_t             msg_q;
    logic [PIN_W-1:0] pin_q;
    logic             found;
    logic [PIN_W-1:0] pick;
    logic [63:0]      pick_ent;

    // Lowest-index eligible pin and its entry.
    always_comb begin
        found    = 1'b0;
        pick     = '0;
        pick_ent = '0;
        for (int i = PINS - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found    = 1'b1;
                pick     = PIN_W'(i);
                pick_ent = entry_i[i];
            end
        end
    end

    // Message register: load when idle, release on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            msg_q   <= '0;
            pin_q   <= '0;
        end else if (valid_q) begin
            if (msg_ready)
                valid_q <= 1'b0;
        end else if (found) begin
            valid_q <= 1'b1;
            msg_q   <= entry_to_msg(pick_ent);
            pin_q   <= pick;
        end
    end

    assign msg_valid = valid_q;
    assign msg_o     = msg_q;
    assign pin_o     = pin_q;
    assign clr_valid = valid_q && msg_ready && !msg_q.trig;
    assign clr_pin   = pin_q;

endmodule

// File: rtl/irq_redirect_ctrl.sv
// Top of the interrupt redirection controller: register file, request capture
// and message sequencer. Assumes a single clock and synchronous inputs.
module irq_redirect_ctrl
    import irc_pkg::*;
#(
    parameter int PINS  = 24,
    parameter int PIN_W = $clog2(PINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_we,
    input  logic [7:0]       acc_off,
    input  logic [31:0]      acc_wdata,
    output logic [31:0]      acc_rdata,
    input  logic [PINS-1:0]  irq_in,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [7:0]       msg_vector,
    output logic [2:0]       msg_dmode,
    output logic             msg_destmode,
    output logic             msg_pol,
    output logic             msg_trig,
    output logic [7:0]       msg_dest,
    output logic [PIN_W-1:0] msg_pin
);

    logic [7:0]       cur_sel;
    logic [63:0]      ent_w [PINS];
    logic [PINS-1:0]  mask_w;
    logic [PINS-1:0]  trig_w;
    logic [PINS-1:0]  pend_w;
    logic [PINS-1:0]  elig;
    logic             clr_valid;
    logic [PIN_W-1:0] clr_pin;
    msg_t             msg_w;

    assign elig = pend_w & ~mask_w;

    irc_regfile #(.PINS(PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_we    (acc_we),
        .acc_off   (acc_off),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata),
        .sel_o     (cur_sel),
        .entry_o   (ent_w),
        .mask_o    (mask_w),
        .trig_o    (trig_w)
    );

    irc_pending #(.PINS(PINS), .PIN_W(PIN_W)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .trig_level (trig_w),
        .clr_valid  (clr_valid),
        .clr_pin    (clr_pin),
        .pend_o     (pend_w)
    );

    irc_sequencer #(.PINS(PINS), .PIN_W(PIN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (elig),
        .entry_i   (ent_w),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg_o     (msg_w),
        .pin_o     (msg_pin),
        .clr_valid (clr_valid),
        .clr_pin   (clr_pin)
    );

    assign msg_vector   = msg_w.vector;
    assign msg_dmode    = msg_w.dmode;
    assign msg_destmode = msg_w.dstm;
    assign msg_pol      = msg_w.pol;
    assign msg_trig     = msg_w.trig;
    assign msg_dest     = msg_w.dest;

endmodule

// File: rtl/irc_checker.sv
// Protocol and ordering properties for the redirection controller, bound to the top.
module irc_checker #(
    parameter int PINS  = 24,
    parameter int PIN_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       acc_off,
    input logic [31:0]      acc_rdata,
    input logic [7:0]       cur_sel,
    input logic [PINS-1:0]  elig,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [7:0]       msg_vector,
    input logic [2:0]       msg_dmode,
    input logic             msg_destmode,
    input logic             msg_pol,
    input logic             msg_trig,
    input logic [7:0]       msg_dest,
    input logic [PIN_W-1:0] msg_pin
);

    localparam logic [31:0] VER_EXP = {8'h00, 8'(PINS - 1), 8'h00, 8'h11};

    logic [PINS-1:0] one_hot;
    logic [PINS-1:0] below;

    assign one_hot = {{(PINS - 1){1'b0}}, 1'b1} << msg_pin;
    assign below   = one_hot - {{(PINS - 1){1'b0}}, 1'b1};

    AST_IDLE_AFTER_RST: assert property (@(posedge clk) !rst_n |=> !msg_valid); // R1

    AST_VER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_off == 8'h10 && cur_sel == 8'h01) |-> acc_rdata == VER_EXP); // R3

    AST_ONLY_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> (($past(elig) & one_hot) != '0)); // R8

    AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> (($past(elig) & below) == '0)); // R9

    AST_HOLD_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> msg_valid &&
        $stable({msg_vector, msg_dmode, msg_destmode, msg_pol, msg_trig, msg_dest, msg_pin})); // R10

endmodule

bind irq_redirect_ctrl irc_checker #(.PINS(PINS), .PIN_W(PIN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_off      (acc_off),
    .acc_rdata    (acc_rdata),
    .cur_sel      (cur_sel),
    .elig         (elig),
    .msg_valid    (msg_valid),
    .msg_ready    (msg_ready),
    .msg_vector   (msg_vector),
    .msg_dmode    (msg_dmode),
    .msg_destmode (msg_destmode),
    .msg_pol      (msg_pol),
    .msg_trig     (msg_trig),
    .msg_dest     (msg_dest),
    .msg_pin      (msg_pin)
);

// File: tb/test_irq_redirect_ctrl.sv
module test_irq_redirect_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int PINS  = 24;
    localparam int PIN_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_we = 1'b0;
    logic [7:0]       acc_off = 8'h00;
    logic [31:0]      acc_wdata = '0;
    logic [31:0]      acc_rdata;
    logic [PINS-1:0]  irq_in = '0;
    logic             msg_valid;
    logic             msg_ready = 1'b0;
    logic [7:0]       msg_vector;
    logic [2:0]       msg_dmode;
    logic             msg_destmode;
    logic             msg_pol;
    logic             msg_trig;
    logic [7:0]       msg_dest;
    logic [PIN_W-1:0] msg_pin;

    int checks = 0;
    int fails  = 0;
    logic [63:0] ent_m [PINS];

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_redirect_ctrl #(.PINS(PINS)) i_irq_redirect_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_we(acc_we), .acc_off(acc_off),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq_in(irq_in),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_dmode(msg_dmode), .msg_destmode(msg_destmode), .msg_pol(msg_pol),
        .msg_trig(msg_trig), .msg_dest(msg_dest), .msg_pin(msg_pin)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] lo_word(input logic [7:0] vec, input logic [2:0] dm,
                                            input logic dstm, input logic pol,
                                            input logic trig, input logic mask);
        return {15'h0, mask, trig, 1'b0, pol, 1'b0, dstm, dm, vec};
    endfunction

    // Called at a falling edge; the write lands at the next rising edge.
    task automatic bus_wr(input logic [7:0] off, input logic [31:0] d);
        acc_we = 1'b1; acc_off = off; acc_wdata = d;
        @(negedge clk);
        acc_we = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] sel, input logic [31:0] d);
        bus_wr(8'h00, {24'h0, sel});
        bus_wr(8'h10, d);
    endtask

    task automatic reg_rd(input logic [7:0] sel, output logic [31:0] d);
        bus_wr(8'h00, {24'h0, sel});
        acc_off = 8'h10;
        #1 d = acc_rdata;
    endtask

    task automatic prog(input int p, input logic [31:0] lo, input logic [31:0] hi);
        reg_wr(8'(8'h10 + 2 * p), lo);
        reg_wr(8'(8'h11 + 2 * p), hi);
        ent_m[p] = {hi, lo};
    endtask

    // Wait for a message, check it against the entry model, hold, then accept.
    task automatic take_msg(input string tag, input int p, input int dly, input logic [PINS-1:0] drop);
        logic [63:0] e;
        int n;
        e = ent_m[p];
        n = 0;
        while (!msg_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        check({tag, " valid"}, 64'(msg_valid), 64'd1);
        check({tag, " pin R9"}, 64'(msg_pin), 64'(p));
        check({tag, " fields R11"},
              {msg_dest, msg_trig, msg_pol, msg_destmode, msg_dmode, msg_vector},
              {e[63:56], e[15], e[13], e[11], e[10:8], e[7:0]});
        repeat (dly) @(negedge clk);
        check({tag, " hold R10"}, {msg_valid, msg_pin, msg_vector}, {1'b1, 5'(p), e[7:0]});
        msg_ready = 1'b1;
        irq_in = irq_in & ~drop;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic expect_quiet(input string tag, input int n);
        logic seen;
        seen = 1'b0;
        repeat (n) begin
            @(negedge clk);
            seen = seen | msg_valid;
        end
        check(tag, 64'(seen), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_1234));
        for (int p = 0; p < PINS; p++) ent_m[p] = 64'h1_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        acc_off = 8'h00; #1 check("R1 select", 64'(acc_rdata), 64'h0);
        check("R1 valid", 64'(msg_valid), 64'h0);
        reg_rd(8'h00, d); check("R1 id", 64'(d), 64'h0);
        reg_rd(8'h10, d); check("R1 entry0 lo", 64'(d), 64'h0001_0000);
        reg_rd(8'h3F, d); check("R1 entry23 hi", 64'(d), 64'h0);

        // R2 select readback and ID top byte
        bus_wr(8'h00, 32'hFFFF_FF2B);
        acc_off = 8'h00; #1 check("R2 select readback", 64'(acc_rdata), 64'h2B);
        @(negedge clk);
        reg_wr(8'h00, 32'hAB12_3456);
        reg_rd(8'h00, d); check("R2 id", 64'(d), 64'hAB00_0000);

        // R3 version read-only; R5 undefined indices and offsets
        reg_rd(8'h01, d); check("R3 version", 64'(d), 64'h0017_0011);
        reg_wr(8'h01, 32'hFFFF_FFFF);
        reg_rd(8'h01, d); check("R3 version after write", 64'(d), 64'h0017_0011);
        reg_rd(8'h02, d); check("R5 index 0x02", 64'(d), 64'h0);
        reg_wr(8'h40, 32'hFFFF_FFFF);
        reg_rd(8'h40, d); check("R5 index 0x40", 64'(d), 64'h0);
        reg_rd(8'h3F, d); check("R5 entry23 hi untouched", 64'(d), 64'h0);
        reg_rd(8'h3E, d); check("R5 entry23 lo untouched", 64'(d), 64'h0001_0000);
        acc_off = 8'h04; #1 check("R5 offset 0x04", 64'(acc_rdata), 64'h0);
        @(negedge clk);

        // R4 halves independent
        reg_wr(8'h1A, 32'h0001_A0B3);
        reg_wr(8'h1B, 32'hCD00_0000);
        reg_rd(8'h1A, d); check("R4 lo kept", 64'(d), 64'h0001_A0B3);
        reg_wr(8'h1A, 32'h0001_0077);
        reg_rd(8'h1B, d); check("R4 hi kept", 64'(d), 64'hCD00_0000);

        // R12 latency, R11 fields, R10 hold, R7 single delivery per edge
        prog(3, lo_word(8'h33, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0), 32'h0500_0000);
        irq_in[3] = 1'b1;
        @(negedge clk); check("R12 not yet", 64'(msg_valid), 64'd0);
        @(negedge clk); check("R12 valid", 64'(msg_valid), 64'd1);
        take_msg("R7 edge", 3, 3, '0);
        expect_quiet("R7 one message per edge", 8);
        irq_in[3] = 1'b0;
        @(negedge clk);
        irq_in[3] = 1'b1;
        take_msg("R7 re-arm", 3, 0, '0);
        irq_in[3] = 1'b0;
        expect_quiet("R7 quiet", 4);

        // R6 level mode follows input
        prog(7, lo_word(8'h47, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0), 32'h2100_0000);
        expect_quiet("R6 low input", 4);
        irq_in[7] = 1'b1;
        take_msg("R6 level first", 7, 0, '0);
        take_msg("R6 level repeat", 7, 0, 24'h00_0080);
        expect_quiet("R6 stops when low", 6);

        // R8 masked pin keeps pending edge
        prog(10, lo_word(8'h5A, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1), 32'h0900_0000);
        irq_in[10] = 1'b1;
        expect_quiet("R8 masked", 6);
        prog(10, lo_word(8'h5A, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), 32'h0900_0000);
        take_msg("R8 after unmask", 10, 0, '0);
        irq_in[10] = 1'b0;

        // R9 ascending order
        prog(20, lo_word(8'hC4, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0), 32'h1400_0000);
        prog(2,  lo_word(8'h22, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0), 32'h0200_0000);
        prog(14, lo_word(8'h8E, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0), 32'h0E00_0000);
        irq_in = irq_in | 24'h10_4004;
        take_msg("R9 first", 2, 1, '0);
        take_msg("R9 second", 14, 1, '0);
        take_msg("R9 third", 20, 1, '0);
        irq_in = '0;
        expect_quiet("R9 drained", 4);

        // Random rounds: R9 R11 R10 R8 against the entry model
        for (int r = 0; r < 6; r++) begin
            logic [PINS-1:0] sub;
            logic [PINS-1:0] msk;
            for (int p = 0; p < PINS; p++) begin
                msk[p] = ($urandom % 4) == 0;
                prog(p, lo_word(8'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'b0, msk[p]),
                     {8'($urandom), 24'h0});
            end
            sub = PINS'($urandom);
            irq_in = sub;
            for (int p = 0; p < PINS; p++)
                if (sub[p] && !msk[p])
                    take_msg("R9 random", p, int'($urandom % 3), '0);
            expect_quiet("R8 random masked quiet", 4);
            irq_in = '0;
            for (int p = 0; p < PINS; p++)
                prog(p, lo_word(8'h0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1), 32'h0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule